// File: doc/BRIEF.md
# GPIO Edge Event Status Unit

This block watches a group of already-filtered GPIO inputs and turns their transitions into two sets of sticky status flags. Each pin has a polarity bit that decides which edge is its "assert" event; the other edge is its "deassert" event. Assert events go to one status register and deassert events go to another. Software that wants both edges of a pin reads both registers.

Each status register drives its own interrupt line. A line is high while any pin has a flag set in that register and has its enable bit set. Software clears flags, or sets them on purpose, through one write whose bit 0 chooses the operation. Each pin's flag sits one bit above its pin number, so bit 0 is free for this mode flag. The normal sequence for a pin is to clear its flags in both status registers and then set its enable bit.

Top module: `gpio_event_unit`

## Requirements
- R1: After reset the polarity, enable, assert-status and deassert-status registers all read 0, and both interrupt outputs are low.
- R2: With a pin's polarity bit at 1, a 0-to-1 change on that pin sets its flag in the assert status, and a 1-to-0 change sets its flag in the deassert status.
- R3: With a pin's polarity bit at 0, a 1-to-0 change sets its assert flag, and a 0-to-1 change sets its deassert flag.
- R4: In both status registers, pin k appears at bit k+1 (pin 0 at bit 1, pin 30 at bit 31). Bit 0 always reads 0.
- R5: A status write with bit 0 equal to 0 clears every flag written as 1 and leaves every other flag unchanged.
- R6: A status write with bit 0 equal to 1 sets every flag written as 1 and leaves every other flag unchanged.
- R7: When an event for a pin and a clear of that same flag fall in the same clock cycle, the flag ends up set.
- R8: Each interrupt output is the registered OR of its status flags ANDed with the enable bits. It follows a status or enable change one clock later.
- R9: A pin whose enable bit is 0 still records its flags, but those flags do not raise either interrupt output.
- R10: Events are found by comparing each pin with its value one cycle earlier. A pin held at a steady level produces no new event, so once its flag is cleared the flag stays cleared.
- R11: Register select 0 is polarity and 1 is enable, with pin k at bit k. Both read back what was written, and bits above the pin count read 0. Select 2 is the assert status and 3 is the deassert status. Read data is registered and shows the selected register one clock after the select is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select: 0 polarity, 1 enable, 2 assert status, 3 deassert status |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data for the selected register |
| pin_in | input | NUM_PINS | Filtered GPIO pin levels |
| irq_assert | output | 1 | Pending enabled assert event |
| irq_deassert | output | 1 | Pending enabled deassert event |

## Verification
A pin edge and a software clear of that pin's flag can land in the same clock cycle. The bench provokes this by changing the pin and issuing the clear write on the same falling clock edge. It then reads the status back and expects the flag to be set. A second clear with no edge must then leave the flag clear. The bench also times each interrupt output against the cycle in which the status changes, to confirm the one-clock lag.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  typedef enum logic [1:0] {
    SEL_POL  = 2'd0,
    SEL_EN   = 2'd1,
    SEL_AST  = 2'd2,
    SEL_DAST = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_evt_edge.sv
module gpio_evt_edge #(
  parameter int N = 31
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_in,
  input  logic [N-1:0] pol,
  output logic [N-1:0] ev_assert,
  output logic [N-1:0] ev_deassert
);
  logic [N-1:0] pin_q;
  logic [N-1:0] rise;
  logic [N-1:0] fall;

  // Reset samples the pins so that release produces no spurious edge.
  always_ff @(posedge clk) begin
    pin_q <= pin_in;
  end

  always_comb begin
    rise        = pin_in & ~pin_q;
    fall        = ~pin_in & pin_q;
    ev_assert   = (rise & pol) | (fall & ~pol);
    ev_deassert = (fall & pol) | (rise & ~pol);
  end

  AST_STEADY_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
    (pin_in == $past(pin_in)) |-> ((ev_assert | ev_deassert) == '0)); // R10
endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status #(
  parameter int N = 31
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] event_in,
  input  logic         wr,
  input  logic [N:0]   wdata,
  output logic [N-1:0] status
);
  logic [N-1:0] mask;
  logic         set_mode;
  logic [N-1:0] sw_next;

  always_comb begin
    mask     = wdata[N:1];
    set_mode = wdata[0];
    sw_next  = status;
    if (wr) begin
      if (set_mode) sw_next = status | mask;
      else          sw_next = status & ~mask;
    end
  end

  // New events are ORed in last so that they win over a same-cycle clear.
  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= sw_next | event_in;
  end

  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (rst)
    (event_in != '0) |=> ((status & $past(event_in)) == $past(event_in))); // R7
  AST_CLEAR_APPLIES: assert property (@(posedge clk) disable iff (rst)
    (wr && !wdata[0]) |=> ((status & $past(wdata[N:1] & ~event_in)) == '0)); // R5
  AST_SET_APPLIES: assert property (@(posedge clk) disable iff (rst)
    (wr && wdata[0]) |=> ((status & $past(wdata[N:1])) == $past(wdata[N:1]))); // R6
endmodule

// File: rtl/gpio_event_unit.sv
module gpio_event_unit #(
  parameter int NUM_PINS = 31,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          reg_sel,
  input  logic                reg_wr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic                irq_assert,
  output logic                irq_deassert
);
  import gpio_evt_pkg::*;

  localparam int STAT_W = NUM_PINS + 1;

  initial begin
    if (NUM_PINS > DATA_W - 1) $error("NUM_PINS must leave bit 0 free for the mode flag");
  end

  reg_sel_e            sel;
  logic [NUM_PINS-1:0] pol_q;
  logic [NUM_PINS-1:0] en_q;
  logic [NUM_PINS-1:0] ev_a;
  logic [NUM_PINS-1:0] ev_d;
  logic [NUM_PINS-1:0] ast_stat;
  logic [NUM_PINS-1:0] dast_stat;
  logic                wr_ast;
  logic                wr_dast;
  logic [DATA_W-1:0]   rd_next;

  assign sel     = reg_sel_e'(reg_sel);
  assign wr_ast  = reg_wr && (sel == SEL_AST);
  assign wr_dast = reg_wr && (sel == SEL_DAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q <= '0;
      en_q  <= '0;
    end else if (reg_wr) begin
      if (sel == SEL_POL) pol_q <= reg_wdata[NUM_PINS-1:0];
      if (sel == SEL_EN)  en_q  <= reg_wdata[NUM_PINS-1:0];
    end
  end

  gpio_evt_edge #(.N(NUM_PINS)) i_edge (
    .clk         (clk),
    .rst         (rst),
    .pin_in      (pin_in),
    .pol         (pol_q),
    .ev_assert   (ev_a),
    .ev_deassert (ev_d)
  );

  gpio_evt_status #(.N(NUM_PINS)) i_ast (
    .clk      (clk),
    .rst      (rst),
    .event_in (ev_a),
    .wr       (wr_ast),
    .wdata    (reg_wdata[STAT_W-1:0]),
    .status   (ast_stat)
  );

  gpio_evt_status #(.N(NUM_PINS)) i_dast (
    .clk      (clk),
    .rst      (rst),
    .event_in (ev_d),
    .wr       (wr_dast),
    .wdata    (reg_wdata[STAT_W-1:0]),
    .status   (dast_stat)
  );

  always_comb begin
    rd_next = '0;
    case (sel)
      SEL_POL:  rd_next[NUM_PINS-1:0] = pol_q;
      SEL_EN:   rd_next[NUM_PINS-1:0] = en_q;
      SEL_AST:  rd_next[STAT_W-1:1]   = ast_stat;
      default:  rd_next[STAT_W-1:1]   = dast_stat;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata    <= '0;
      irq_assert   <= 1'b0;
      irq_deassert <= 1'b0;
    end else begin
      reg_rdata    <= rd_next;
      irq_assert   <= |(ast_stat & en_q);
      irq_deassert <= |(dast_stat & en_q);
    end
  end

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> (!irq_assert && !irq_deassert)); // R9
  AST_MODE_BIT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_sel[1] == 1'b1) |=> (reg_rdata[0] == 1'b0)); // R4
endmodule

// File: tb/test_gpio_event_unit.sv
module test_gpio_event_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 31;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    reg_sel = 2'd0;
  logic          reg_wr = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [NP-1:0] pin_in = '0;
  logic          irq_assert;
  logic          irq_deassert;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_event_unit #(.NUM_PINS(NP), .DATA_W(DW)) i_gpio_event_unit (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .irq_assert(irq_assert), .irq_deassert(irq_deassert)
  );

  task automatic check(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [DW-1:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [1:0] s, output logic [DW-1:0] d);
    @(negedge clk);
    reg_sel = s;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic set_pins(logic [NP-1:0] v);
    @(negedge clk);
    pin_in = v;
    @(negedge clk);
  endtask

  task automatic clear_all();
    wr(2'd2, 32'hFFFF_FFFE);
    wr(2'd3, 32'hFFFF_FFFE);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    for (int s = 0; s < 4; s++) begin
      rd(s[1:0], d);
      check("R1 register after reset", d, '0);
    end
    check("R1 irq_assert after reset", {31'd0, irq_assert}, '0);
    check("R1 irq_deassert after reset", {31'd0, irq_deassert}, '0);
  endtask

  task automatic t_pol_high();
    logic [DW-1:0] d;
    wr(2'd0, 32'h1);
    set_pins(31'h1);
    rd(2'd2, d); check("R2 rise pol1 assert, R4 pin0 at bit1", d, 32'h2);
    rd(2'd3, d); check("R2 rise pol1 no deassert", d, 32'h0);
    set_pins(31'h0);
    rd(2'd3, d); check("R2 fall pol1 deassert", d, 32'h2);
    check("R9 disabled pin no irq_assert", {31'd0, irq_assert}, '0);
    check("R9 disabled pin no irq_deassert", {31'd0, irq_deassert}, '0);
    wr(2'd2, 32'h2);
    rd(2'd2, d); check("R5 clear assert flag", d, 32'h0);
    rd(2'd3, d); check("R5 other register untouched", d, 32'h2);
    clear_all();
  endtask

  task automatic t_pol_low();
    logic [DW-1:0] d;
    wr(2'd0, 32'h0);
    set_pins(31'h4000_0000);
    rd(2'd3, d); check("R3 rise pol0 deassert, R4 pin30 at bit31", d, 32'h8000_0000);
    rd(2'd2, d); check("R3 rise pol0 no assert", d, 32'h0);
    set_pins(31'h0);
    rd(2'd2, d); check("R3 fall pol0 assert", d, 32'h8000_0000);
    clear_all();
    rd(2'd2, d); check("R5 clear all assert", d, 32'h0);
  endtask

  task automatic t_set_mode();
    logic [DW-1:0] d;
    wr(2'd2, 32'h0000_0017);
    rd(2'd2, d); check("R6 set mode, R4 bit0 reads 0", d, 32'h0000_0016);
    wr(2'd2, 32'h0000_0009);
    rd(2'd2, d); check("R6 set keeps other flags", d, 32'h0000_001E);
    wr(2'd2, 32'h0000_0004);
    rd(2'd2, d); check("R5 partial clear", d, 32'h0000_001A);
    clear_all();
  endtask

  task automatic t_irq();
    wr(2'd1, 32'h8);
    wr(2'd2, 32'h11);
    check("R8 irq lags status by one clock", {31'd0, irq_assert}, 32'h0);
    @(negedge clk);
    check("R8 irq_assert raised", {31'd0, irq_assert}, 32'h1);
    wr(2'd3, 32'h21);
    @(negedge clk);
    check("R9 deassert flag of disabled pin", {31'd0, irq_deassert}, 32'h0);
    wr(2'd1, 32'h18);
    @(negedge clk);
    check("R8 enabling pin raises irq_deassert", {31'd0, irq_deassert}, 32'h1);
    wr(2'd2, 32'h10);
    check("R8 irq still high on clear cycle", {31'd0, irq_assert}, 32'h1);
    @(negedge clk);
    check("R8 irq_assert drops after clear", {31'd0, irq_assert}, 32'h0);
    clear_all();
    wr(2'd1, 32'h0);
  endtask

  task automatic t_race();
    logic [DW-1:0] d;
    wr(2'd0, 32'h80);
    @(negedge clk);
    pin_in = 31'h80;
    reg_sel = 2'd2; reg_wdata = 32'h100; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    rd(2'd2, d); check("R7 event beats same-cycle clear", d, 32'h100);
    wr(2'd2, 32'h100);
    @(negedge clk);
    rd(2'd2, d); check("R10 steady pin stays cleared", d, 32'h0);
    set_pins(31'h0);
    clear_all();
  endtask

  task automatic t_readback();
    logic [DW-1:0] d;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); check("R11 polarity readback", d, 32'h7FFF_FFFF);
    wr(2'd1, 32'hA5A5_5A5A);
    rd(2'd1, d); check("R11 enable readback", d, 32'h25A5_5A5A);
    rd(2'd2, d); check("R11 polarity write causes no event", d, 32'h0);
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_pol_high();
    t_pol_low();
    t_set_mode();
    t_irq();
    t_race();
    t_readback();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule